// File: doc/BRIEF.md
# Configurable I/O Cell

This block models one programmable I/O cell that sits between a package pad and the core logic. The pad is split into three plain signals: a value driven out, an output enable and a value read in. The input side always offers two copies of the pad value to the core. One is the live pad level. The other passes through a storage element that a configuration bit turns into either an edge-triggered flip-flop or a level-sensitive latch. The output side drives the pad either straight from the core or through a register. Separate configuration bits can invert the output data and the output enable.

Each side picks its own clock from two shared clock lines, and each side can invert the sense of that clock. An eight-bit configuration word is loaded from the configuration-word input on a rising edge of clock line A, but only while the configuration-active flag is high. The word stays fixed during normal operation. Both storage elements are cleared at once, without waiting for a clock, while the configuration-active flag is high or the active-low chip reset is low.

Top module: `iocell`

## Requirements
- R1: The configuration word is captured from `cfg_word` on a rising edge of `clk_a` only while `cfg_active` is high. A word presented while `cfg_active` is low has no effect on the pad or core outputs. Bit positions: 0 input latch mode, 1 input clock invert, 2 input line select (0 = line A, 1 = line B), 3 output line select, 4 output clock invert, 5 registered output, 6 output data invert, 7 output enable invert.
- R2: `core_din` equals `pad_in` at all times, with no clock involved.
- R3: In flip-flop mode (bit 0 = 0), `core_rin` takes `pad_in` on the rising edge of the selected input line, or on its falling edge when bit 1 is set, and holds that value between those edges.
- R4: In latch mode (bit 0 = 1), `core_rin` follows `pad_in` while the selected input line is low (high when bit 1 is set), including changes in the middle of that phase, and holds the value in the other phase.
- R5: Bit 2 picks the input clock line; edges and levels on the other line have no effect on `core_rin`.
- R6: With bit 5 set, the pad data comes from a register that captures `core_out` on the rising edge of the output line chosen by bit 3, or on its falling edge when bit 4 is set. With bit 5 clear, the pad data follows `core_out` directly.
- R7: `pad_out` is the selected output data XOR bit 6.
- R8: `pad_oe` is `core_en` XOR bit 7. The pad is driven only while `pad_oe` is 1.
- R9: While `cfg_active` is high or `rst_n` is low, both storage elements hold 0, whatever the clock edges or latch transparency. `core_rin` then reads 0, and a registered output shows bit 6 on `pad_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Shared clock line A; also clocks configuration loading |
| clk_b | input | 1 | Shared clock line B |
| rst_n | input | 1 | Active-low chip reset, asynchronous clear of storage |
| cfg_active | input | 1 | Configuration in progress; enables loading and clears storage |
| cfg_word | input | 8 | Configuration word to load |
| pad_in | input | WIDTH | Level seen at the pad |
| pad_out | output | WIDTH | Value driven to the pad |
| pad_oe | output | WIDTH | Pad drive enable, active high |
| core_din | output | WIDTH | Direct pad value to the core |
| core_rin | output | WIDTH | Stored pad value to the core |
| core_out | input | WIDTH | Core data for the pad |
| core_en | input | WIDTH | Core tri-state control before polarity |

## Verification
All eight combinations of data polarity, enable polarity, core data and core enable run through the direct output path. This separates a swapped or missing inversion on either output. The input element is tried as a flip-flop and as a latch, on both clock senses and on both lines. Pad changes placed in the middle of a clock phase separate latch transparency from edge capture, and they also show a wrong clock sense or a wrong line select. Clears are applied mid-phase, while the latch is open or a flip-flop holds a 1, to show that they take effect at once and override the clock. A write offered while the configuration flag is low confirms that the configuration word cannot be changed outside configuration.

// File: rtl/iocell_pkg.sv
`timescale 1ns/1ps
package iocell_pkg;

  // Static configuration word, bit 0 is the lowest field
  typedef struct packed {
    logic oe_pol;       // 7: invert output enable
    logic out_pol;      // 6: invert output data
    logic out_reg;      // 5: registered output path
    logic out_inv_clk;  // 4: output clock sense inverted
    logic out_sel;      // 3: output clock line, 0 = A, 1 = B
    logic in_sel;       // 2: input clock line, 0 = A, 1 = B
    logic in_inv;       // 1: input clock sense inverted
    logic in_latch;     // 0: input element is a latch
  } iocell_cfg_t;

  localparam int CFG_W = $bits(iocell_cfg_t);

endpackage

// File: rtl/iocell_clk_pick.sv
`timescale 1ns/1ps
module iocell_clk_pick (
  input  logic line_a,
  input  logic line_b,
  input  logic sel,
  input  logic inv,
  output logic gclk
);

  logic picked;

  always_comb begin
    picked = sel ? line_b : line_a;
    gclk   = picked ^ inv;
  end

endmodule

// File: rtl/iocell_in_store.sv
`timescale 1ns/1ps
module iocell_in_store #(
  parameter int WIDTH = 1
) (
  input  logic             gclk,
  input  logic             clr,
  input  logic             use_latch,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] ff_q;
  logic [WIDTH-1:0] lat_q;

  // edge element: rising edge of the local (sense-adjusted) clock
  always_ff @(posedge gclk or posedge clr) begin
    if (clr) ff_q <= '0;
    else     ff_q <= d;
  end

  // level element: open while the local clock is low
  always_latch begin
    if (clr)        lat_q <= '0;
    else if (!gclk) lat_q <= d;
  end

  assign q = use_latch ? lat_q : ff_q;

endmodule

// File: rtl/iocell_out_stage.sv
`timescale 1ns/1ps
module iocell_out_stage #(
  parameter int WIDTH = 1
) (
  input  logic             gclk,
  input  logic             clr,
  input  logic             use_reg,
  input  logic             out_pol,
  input  logic             oe_pol,
  input  logic [WIDTH-1:0] core_out,
  input  logic [WIDTH-1:0] core_en,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] out_q
);

  logic [WIDTH-1:0] data_sel;

  always_ff @(posedge gclk or posedge clr) begin
    if (clr) out_q <= '0;
    else     out_q <= core_out;
  end

  always_comb begin
    data_sel = use_reg ? out_q : core_out;
    pad_out  = data_sel ^ {WIDTH{out_pol}};
    pad_oe   = core_en ^ {WIDTH{oe_pol}};
  end

endmodule

// File: rtl/iocell.sv
`timescale 1ns/1ps
module iocell #(
  parameter int WIDTH = 1
) (
  input  logic                         clk_a,
  input  logic                         clk_b,
  input  logic                         rst_n,
  input  logic                         cfg_active,
  input  logic [iocell_pkg::CFG_W-1:0] cfg_word,
  input  logic [WIDTH-1:0]             pad_in,
  output logic [WIDTH-1:0]             pad_out,
  output logic [WIDTH-1:0]             pad_oe,
  output logic [WIDTH-1:0]             core_din,
  output logic [WIDTH-1:0]             core_rin,
  input  logic [WIDTH-1:0]             core_out,
  input  logic [WIDTH-1:0]             core_en
);
  import iocell_pkg::*;

  iocell_cfg_t      cfg_q;
  logic             clr;
  logic             in_gclk;
  logic             out_gclk;
  logic [WIDTH-1:0] out_q;

  // configuration store: static outside configuration
  always_ff @(posedge clk_a) begin
    if (cfg_active) cfg_q <= iocell_cfg_t'(cfg_word);
  end

  assign clr      = cfg_active | ~rst_n;
  assign core_din = pad_in;

  iocell_clk_pick u_in_clk (
    .line_a (clk_a),
    .line_b (clk_b),
    .sel    (cfg_q.in_sel),
    .inv    (cfg_q.in_inv),
    .gclk   (in_gclk)
  );

  iocell_clk_pick u_out_clk (
    .line_a (clk_a),
    .line_b (clk_b),
    .sel    (cfg_q.out_sel),
    .inv    (cfg_q.out_inv_clk),
    .gclk   (out_gclk)
  );

  iocell_in_store #(.WIDTH(WIDTH)) u_in (
    .gclk      (in_gclk),
    .clr       (clr),
    .use_latch (cfg_q.in_latch),
    .d         (pad_in),
    .q         (core_rin)
  );

  iocell_out_stage #(.WIDTH(WIDTH)) u_out (
    .gclk     (out_gclk),
    .clr      (clr),
    .use_reg  (cfg_q.out_reg),
    .out_pol  (cfg_q.out_pol),
    .oe_pol   (cfg_q.oe_pol),
    .core_out (core_out),
    .core_en  (core_en),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .out_q    (out_q)
  );

endmodule

// File: rtl/iocell_chk.sv
`timescale 1ns/1ps
module iocell_chk #(
  parameter int WIDTH = 1
) (
  input logic                    clk_a,
  input logic                    rst_n,
  input logic                    cfg_active,
  input iocell_pkg::iocell_cfg_t cfg_q,
  input logic [WIDTH-1:0]        pad_in,
  input logic [WIDTH-1:0]        core_rin,
  input logic [WIDTH-1:0]        core_out,
  input logic [WIDTH-1:0]        pad_out,
  input logic [WIDTH-1:0]        out_q
);

  // R1
  cfg_static_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    !cfg_active |=> $stable(cfg_q));

  // R9
  cfg_clears_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    cfg_active |-> (core_rin == '0 && out_q == '0));

  // R3
  ff_capture_chk: assert property (@(posedge clk_a) disable iff (!rst_n || cfg_active)
    (!cfg_q.in_latch && !cfg_q.in_sel && !cfg_q.in_inv) |=> core_rin == $past(pad_in));

  // R4
  latch_open_chk: assert property (@(posedge clk_a) disable iff (!rst_n || cfg_active)
    (cfg_q.in_latch && !cfg_q.in_sel && !cfg_q.in_inv) |-> core_rin == pad_in);

  // R6
  out_reg_chk: assert property (@(posedge clk_a) disable iff (!rst_n || cfg_active)
    (cfg_q.out_reg && !cfg_q.out_sel && !cfg_q.out_inv_clk)
      |=> pad_out == $past(core_out ^ {WIDTH{cfg_q.out_pol}}));

endmodule

bind iocell iocell_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_a      (clk_a),
  .rst_n      (rst_n),
  .cfg_active (cfg_active),
  .cfg_q      (cfg_q),
  .pad_in     (pad_in),
  .core_rin   (core_rin),
  .core_out   (core_out),
  .pad_out    (pad_out),
  .out_q      (out_q)
);

// File: tb/tb_iocell.sv
`timescale 1ns/1ps
module tb_iocell;

  logic       clk_a = 1'b0;
  logic       clk_b = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_active = 1'b0;
  logic [7:0] cfg_word = '0;
  logic       pad_in = 1'b0;
  logic       pad_out, pad_oe, core_din, core_rin;
  logic       core_out = 1'b0;
  logic       core_en = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk_a = ~clk_a;   // 200 MHz line A; line B driven by hand

  iocell #(.WIDTH(1)) dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .cfg_active(cfg_active),
    .cfg_word(cfg_word), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .core_din(core_din), .core_rin(core_rin), .core_out(core_out), .core_en(core_en)
  );

  // [5] out_pol [4] oe_pol [3] core_out [2] core_en [1] exp pad_out [0] exp pad_oe
  localparam logic [5:0] VEC [8] = '{
    6'b000000, 6'b001111, 6'b100111, 6'b101000,
    6'b010100, 6'b011011, 6'b111100, 6'b110011
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic load_cfg(input logic [7:0] c);
    @(negedge clk_a); #0.5;
    cfg_word = c; cfg_active = 1'b1;
    @(negedge clk_a); #0.5;
    cfg_active = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    load_cfg(8'h00);
    repeat (2) @(posedge clk_a);
    #0.5;
    chk("R9 reset state core_rin", core_rin, 1'b0);
    @(negedge clk_a); #0.5 rst_n = 1'b1;
    #0.5;
    chk("R8 reset state pad_oe", pad_oe, 1'b0);
    chk("R7 reset state pad_out", pad_out, 1'b0);

    // R1: write with flag low is ignored, with flag high it lands
    @(negedge clk_a); #0.5 cfg_word = 8'h40;
    @(posedge clk_a); @(negedge clk_a); #0.5;
    chk("R1 write ignored when flag low", pad_out, 1'b0);
    load_cfg(8'h40);
    #0.5 chk("R1 write taken when flag high", pad_out, 1'b1);

    // R7 R8: direct output path table
    foreach (VEC[i]) begin
      load_cfg({VEC[i][4], VEC[i][5], 6'b0});
      core_out = VEC[i][3]; core_en = VEC[i][2];
      #0.5;
      chk("R7 table pad_out", pad_out, VEC[i][1]);
      chk("R8 table pad_oe", pad_oe, VEC[i][0]);
    end

    // R2: direct copy follows pad at once
    for (int k = 0; k < 4; k++) begin
      pad_in = k[0]; #0.3;
      chk("R2 core_din follows pad_in", core_din, k[0]);
    end
    pad_in = 1'b0;

    // R3: flip-flop, line A, rising edge
    load_cfg(8'h00);
    pad_in = 1'b1; #0.5;
    chk("R3 ff holds before rising edge", core_rin, 1'b0);
    @(posedge clk_a); #0.5;
    chk("R3 ff captures on rising edge", core_rin, 1'b1);
    pad_in = 1'b0; #0.5;
    chk("R3 ff holds after pad change", core_rin, 1'b1);

    // R3: flip-flop, line A, falling edge
    load_cfg(8'h02);
    @(posedge clk_a); #0.5 pad_in = 1'b1; #0.5;
    chk("R3 inverted ff ignores rising edge", core_rin, 1'b0);
    @(negedge clk_a); #0.5;
    chk("R3 inverted ff captures on falling edge", core_rin, 1'b1);
    pad_in = 1'b0;

    // R5: flip-flop on line B
    load_cfg(8'h04);
    pad_in = 1'b1;
    repeat (2) @(posedge clk_a);
    #0.5 chk("R5 line A edges ignored", core_rin, 1'b0);
    clk_b = 1'b1; #0.5;
    chk("R5 line B edge captures", core_rin, 1'b1);
    clk_b = 1'b0; pad_in = 1'b0;

    // R4: latch, line A, open while low
    load_cfg(8'h01);
    #0.5 pad_in = 1'b1; #0.5;
    chk("R4 latch open mid low phase", core_rin, 1'b1);
    @(posedge clk_a); #0.5 pad_in = 1'b0; #0.5;
    chk("R4 latch holds in high phase", core_rin, 1'b1);
    @(negedge clk_a); #0.5;
    chk("R4 latch reopens in low phase", core_rin, 1'b0);

    // R4: latch, line A, open while high
    load_cfg(8'h03);
    @(posedge clk_a); #0.5 pad_in = 1'b1; #0.5;
    chk("R4 inverted latch open mid high phase", core_rin, 1'b1);
    @(negedge clk_a); #0.5 pad_in = 1'b0; #0.5;
    chk("R4 inverted latch holds in low phase", core_rin, 1'b1);
    @(posedge clk_a); #0.5;
    chk("R4 inverted latch reopens", core_rin, 1'b0);

    // R4 R5: latch on line B
    load_cfg(8'h05);
    pad_in = 1'b1; #0.5;
    chk("R5 latch on line B open while B low", core_rin, 1'b1);
    clk_b = 1'b1; #0.2 pad_in = 1'b0; #0.5;
    chk("R5 latch on line B holds while B high", core_rin, 1'b1);
    clk_b = 1'b0; #0.5;
    chk("R5 latch on line B reopens", core_rin, 1'b0);

    // R6: registered output, line A, rising edge
    load_cfg(8'h20);
    core_en = 1'b1; core_out = 1'b1; #0.5;
    chk("R6 reg output waits for edge", pad_out, 1'b0);
    @(posedge clk_a); #0.5;
    chk("R6 reg output captures on rising edge", pad_out, 1'b1);

    // R6 R7: registered output, line B, falling edge, inverted data
    load_cfg(8'h78);
    #0.5 chk("R9 cleared reg output shows polarity", pad_out, 1'b1);
    clk_b = 1'b1; #0.5;
    chk("R6 rising B edge ignored when inverted", pad_out, 1'b1);
    clk_b = 1'b0; #0.5;
    chk("R6 falling B edge captures, R7 inverts", pad_out, 1'b0);
    core_out = 1'b0;
    repeat (2) @(posedge clk_a);
    #0.5 chk("R6 line A ignored for output on B", pad_out, 1'b0);

    // R9: chip reset clears flip-flops and overrides edges
    load_cfg(8'h20);
    core_out = 1'b1; pad_in = 1'b1;
    @(posedge clk_a); #0.5;
    chk("R3 ff set before reset", core_rin, 1'b1);
    rst_n = 1'b0; #0.5;
    chk("R9 reset clears input ff", core_rin, 1'b0);
    chk("R9 reset clears output reg", pad_out, 1'b0);
    @(posedge clk_a); #0.5;
    chk("R9 reset overrides edge", core_rin, 1'b0);
    @(negedge clk_a); #0.5 rst_n = 1'b1;
    @(posedge clk_a); #0.5;
    chk("R3 ff captures after reset", core_rin, 1'b1);

    // R9: reset overrides an open latch
    load_cfg(8'h01);
    #0.5 chk("R4 latch open with pad high", core_rin, 1'b1);
    rst_n = 1'b0; #0.5;
    chk("R9 reset overrides open latch", core_rin, 1'b0);
    rst_n = 1'b1; #0.5;
    chk("R4 latch reopens after reset", core_rin, 1'b1);

    // R9: configuration flag clears mid phase
    cfg_word = 8'h01; cfg_active = 1'b1; #0.5;
    chk("R9 config flag clears latch", core_rin, 1'b0);
    @(negedge clk_a); #0.5 cfg_active = 1'b0;
    pad_in = 1'b0;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule